// File: doc/BRIEF.md
# ADC Sample and Convert Sequencer

This block is the digital timing controller placed in front of a sample-and-hold analog-to-digital converter. It closes and opens the sample switch, issues a one-cycle convert-start strobe, times a fixed-length conversion busy period and flags its end. It also requests power for the converter reference. Configuration arrives as plain input ports. The converter itself is modelled only as the busy period.

The block has two sampling disciplines. In synchronous mode, a rising edge on the trigger opens a sampling window of 2^(e+1) clock periods. Conversion follows that window with no gap. In asynchronous mode, the sample switch tracks continuously while the block runs. A trigger edge freezes the sample and starts conversion, and tracking resumes automatically once the conversion ends.

The sequencer runs only while both the enable and the active-low soft reset are high. Software pulses the soft reset low after every configuration change.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After hardware reset, and in any cycle after enable or soft_rst_n was low, sample_on, conv_start, conv_done and ref_pwr_req are all 0. A trigger edge in that state starts nothing.
- R2: In synchronous mode (async_mode = 0) with the block idle, raising trig_in before clock edge N makes sample_on high from edge N+2 onward: two synchronizer stages, then an edge detector.
- R3: The synchronous window keeps sample_on high for exactly 2^(e+1) cycles. Here e is smpl_exp (4-bit unsigned), and codes 0, 1 and 2 are treated as 3, so the window is 16 cycles for them and 65536 cycles for code 15.
- R4: conv_start is high for exactly one cycle, the cycle right after the last sampling cycle. sample_on is 0 in that cycle.
- R5: A conversion lasts CONV_CYCLES cycles (16 by default), counting the conv_start cycle. conv_done is high for one cycle, the last of them. In synchronous mode sample_on stays 0 afterwards until a new trigger.
- R6: In asynchronous mode (async_mode = 1), sample_on is high one cycle after the block starts running and stays high until a trigger edge. A trigger raised before edge N makes conv_start high from edge N+2. smpl_exp has no effect in this mode.
- R7: In asynchronous mode, sample_on returns to 1 in the cycle right after the conv_done cycle.
- R8: A trigger edge that arrives while a window or a conversion is in progress is ignored and not queued. The window length is unchanged, and the block returns to idle after conv_done.
- R9: ref_pwr_req is 1 while the block runs and is sampling or converting, and whenever it runs in asynchronous mode. In synchronous idle it equals ref_keep.
- R10: Dropping soft_rst_n during a window returns the block to idle in the next cycle. The window does not resume when soft_rst_n is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| enable | input | 1 | Gates all sequencer activity |
| soft_rst_n | input | 1 | Active-low soft reset that returns the sequencer to idle |
| async_mode | input | 1 | 0 selects synchronous window, 1 selects continuous tracking |
| smpl_exp | input | 4 | Sampling window exponent (synchronous mode only) |
| ref_keep | input | 1 | Keeps the reference powered in synchronous idle |
| trig_in | input | 1 | Trigger, may be asynchronous to clk |
| sample_on | output | 1 | Sample switch closed |
| conv_start | output | 1 | One-cycle strobe at the start of a conversion |
| ref_pwr_req | output | 1 | Reference power request |
| conv_done | output | 1 | One-cycle pulse in the last conversion cycle |

## Verification
Each kind of wrong internal state shows up at the ports in a definite way:
- A wrong window count shows as a sample_on run of the wrong length. The sweep over every exponent code catches it within one window.
- A wrong transition shows at once, in the same cycle, as conv_start appearing together with sample_on or away from the end of the window.
- A lost return path shows one cycle after conv_done: sample_on stays low in asynchronous mode, or turns high in synchronous mode.
- A queued trigger shows as a second window after the first conversion.
- A stuck state after a soft reset shows in the following cycle as sample_on still high.

// File: rtl/adc_seq_pkg.sv
// Package: shared state type and window arithmetic for the ADC sequencer.
// Assumes the exponent is an unsigned code no wider than 31 bits.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_TRACK  = 2'd2,
        ST_CONV   = 2'd3
    } seq_state_t;

    // Counter preload for a synchronous window: 2^(max(e,min_e)+1) - 1.
    function automatic logic [31:0] window_preload(input int unsigned e,
                                                   input int unsigned min_e);
        int unsigned eff;
        eff = (e < min_e) ? min_e : e;
        return (32'd1 << (eff + 1)) - 32'd1;
    endfunction

endpackage

// File: rtl/adc_trig_sync.sv
// Module: two-flop synchronizer followed by a rising-edge detector.
// Assumes trig_in may change at any time relative to clk. The edge output
// is a single-cycle pulse, two cycles after the first capture flop sees 1.
module adc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_edge
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw trigger through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], trig_in};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign trig_edge = sync_q[STAGES-1] & ~prev_q;

    // R2
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_edge |=> !trig_edge);

endmodule

// File: rtl/adc_seq_counter.sv
// Module: loadable down counter that stops at zero.
// Assumes the load has priority over counting; zero flags the final count.
module adc_seq_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             at_zero
);
    logic [WIDTH-1:0] cnt_q;

    // Preload on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_fsm.sv
// Module: sequencer state machine. It chooses between the synchronous
// window and the asynchronous tracking discipline and drives the outputs.
// Assumes the counters report zero in the last cycle of each period, and
// that the mode and exponent change only while run is low.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int EXP_W       = 4,
    parameter int MIN_EXP     = 3,
    parameter int WIN_W       = 16,
    parameter int CONV_CYCLES = 16,
    parameter int CONV_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             async_mode,
    input  logic [EXP_W-1:0] smpl_exp,
    input  logic             ref_keep,
    input  logic             trig_edge,
    input  logic             win_zero,
    input  logic             conv_zero,
    output logic             win_load,
    output logic [WIN_W-1:0] win_val,
    output logic             conv_load,
    output logic [CONV_W-1:0] conv_val,
    output logic             sample_on,
    output logic             conv_start,
    output logic             ref_pwr_req,
    output logic             conv_done
);
    seq_state_t state_q, state_d;
    logic       first_q;
    logic [31:0] preload;

    // Window preload for the current exponent, clamped to the minimum.
    always_comb begin
        preload = window_preload(int'(smpl_exp), MIN_EXP);
        win_val = preload[WIN_W-1:0];
    end

    localparam logic [31:0] CONV_PRE = CONV_CYCLES - 1;
    assign conv_val = CONV_PRE[CONV_W-1:0];

    // Next-state and counter-load decisions.
    always_comb begin
        state_d   = state_q;
        win_load  = 1'b0;
        conv_load = 1'b0;
        if (!run) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (async_mode) begin
                        state_d = ST_TRACK;
                    end else if (trig_edge) begin
                        state_d  = ST_WINDOW;
                        win_load = 1'b1;
                    end
                end
                ST_WINDOW: begin
                    if (win_zero) begin
                        state_d   = ST_CONV;
                        conv_load = 1'b1;
                    end
                end
                ST_TRACK: begin
                    if (trig_edge) begin
                        state_d   = ST_CONV;
                        conv_load = 1'b1;
                    end
                end
                ST_CONV: begin
                    if (conv_zero) state_d = async_mode ? ST_TRACK : ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Marks the first cycle of a conversion for the start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= conv_load;
    end

    assign sample_on   = (state_q == ST_WINDOW) || (state_q == ST_TRACK);
    assign conv_start  = (state_q == ST_CONV) && first_q;
    assign conv_done   = (state_q == ST_CONV) && conv_zero;
    assign ref_pwr_req = run && (async_mode || ref_keep || (state_q != ST_IDLE));

    // R4
    start_no_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !sample_on);

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    // R7
    async_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && run && async_mode) ##1 run |-> sample_on);

    // R1
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!sample_on && !conv_start && !conv_done));

    // R9
    busy_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (sample_on || conv_start || conv_done)) |-> ref_pwr_req);

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: top of the ADC sample and convert sequencer. It connects the
// trigger synchronizer, the window and conversion counters and the FSM.
// Assumes configuration is stable while enable and soft_rst_n are high.
module adc_seq_ctrl #(
    parameter int EXP_W       = 4,
    parameter int MIN_EXP     = 3,
    parameter int SYNC_STAGES = 2,
    parameter int CONV_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             soft_rst_n,
    input  logic             async_mode,
    input  logic [EXP_W-1:0] smpl_exp,
    input  logic             ref_keep,
    input  logic             trig_in,
    output logic             sample_on,
    output logic             conv_start,
    output logic             ref_pwr_req,
    output logic             conv_done
);
    localparam int MAX_EXP = (1 << EXP_W) - 1;
    localparam int WIN_W   = MAX_EXP + 1;
    localparam int CONV_W  = $clog2(CONV_CYCLES + 1);

    logic              run;
    logic              trig_edge;
    logic              win_load, conv_load, win_zero, conv_zero;
    logic [WIN_W-1:0]  win_val;
    logic [CONV_W-1:0] conv_val;

    assign run = enable && soft_rst_n;

    adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_edge(trig_edge)
    );

    adc_seq_counter #(.WIDTH(WIN_W)) u_win_cnt (
        .clk(clk), .rst_n(rst_n), .load(win_load), .load_val(win_val),
        .at_zero(win_zero)
    );

    adc_seq_counter #(.WIDTH(CONV_W)) u_conv_cnt (
        .clk(clk), .rst_n(rst_n), .load(conv_load), .load_val(conv_val),
        .at_zero(conv_zero)
    );

    adc_seq_fsm #(
        .EXP_W(EXP_W), .MIN_EXP(MIN_EXP), .WIN_W(WIN_W),
        .CONV_CYCLES(CONV_CYCLES), .CONV_W(CONV_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .async_mode(async_mode),
        .smpl_exp(smpl_exp), .ref_keep(ref_keep), .trig_edge(trig_edge),
        .win_zero(win_zero), .conv_zero(conv_zero),
        .win_load(win_load), .win_val(win_val),
        .conv_load(conv_load), .conv_val(conv_val),
        .sample_on(sample_on), .conv_start(conv_start),
        .ref_pwr_req(ref_pwr_req), .conv_done(conv_done)
    );

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CONV_LEN   = 16;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       soft_rst_n = 1'b0;
    logic       async_mode = 1'b0;
    logic [3:0] smpl_exp = 4'd0;
    logic       ref_keep = 1'b0;
    logic       trig_in = 1'b0;
    logic       sample_on, conv_start, ref_pwr_req, conv_done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst_n(soft_rst_n),
        .async_mode(async_mode), .smpl_exp(smpl_exp), .ref_keep(ref_keep),
        .trig_in(trig_in), .sample_on(sample_on), .conv_start(conv_start),
        .ref_pwr_req(ref_pwr_req), .conv_done(conv_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int win_len(input int e);
        int eff;
        eff = (e < 3) ? 3 : e;
        return 1 << (eff + 1);
    endfunction

    // Synchronous window; optional extra trigger inside the window.
    task automatic sync_run(input int e, input bit retrig);
        int cnt;
        int len;
        smpl_exp = 4'(e);
        trig_in  = 1'b1;
        step(); step();
        check(sample_on == 1'b0, "R2 latency early", int'(sample_on), 0);
        step();
        check(sample_on == 1'b1, "R2 latency", int'(sample_on), 1);
        check(ref_pwr_req == 1'b1, "R9 busy ref", int'(ref_pwr_req), 1);
        trig_in = 1'b0;
        cnt = 1;
        while (sample_on && cnt < 70000) begin
            if (retrig && cnt == 4) trig_in = 1'b1;
            if (retrig && cnt == 9) trig_in = 1'b0;
            step();
            if (sample_on) cnt++;
        end
        check(cnt == win_len(e), retrig ? "R8 window unchanged" : "R3 window length",
              cnt, win_len(e));
        check(conv_start == 1'b1, "R4 start after window", int'(conv_start), 1);
        len = 1;
        if (retrig) trig_in = 1'b1;
        while (!conv_done && len < 100) begin
            step();
            len++;
            if (len == 2) check(conv_start == 1'b0, "R4 start one cycle", int'(conv_start), 0);
        end
        trig_in = 1'b0;
        check(len == CONV_LEN, "R5 conversion length", len, CONV_LEN);
        step();
        check(conv_done == 1'b0, "R5 done one cycle", int'(conv_done), 0);
        check(sample_on == 1'b0, "R5 sync idle after", int'(sample_on), 0);
        if (retrig) begin
            int seen;
            seen = 0;
            for (int i = 0; i < 8; i++) begin
                step();
                if (sample_on) seen++;
            end
            check(seen == 0, "R8 not queued", seen, 0);
        end
        step();
    endtask

    task automatic async_run(input int e);
        int len;
        smpl_exp = 4'(e);
        check(sample_on == 1'b1, "R6 tracking", int'(sample_on), 1);
        check(ref_pwr_req == 1'b1, "R9 async ref", int'(ref_pwr_req), 1);
        trig_in = 1'b1;
        step(); step();
        check(sample_on == 1'b1, "R6 latency early", int'(sample_on), 1);
        step();
        check(conv_start == 1'b1 && sample_on == 1'b0, "R6 trigger ends tracking",
              int'(conv_start), 1);
        trig_in = 1'b0;
        len = 1;
        while (!conv_done && len < 100) begin
            step();
            len++;
        end
        check(len == CONV_LEN, "R6 conversion length", len, CONV_LEN);
        step();
        check(sample_on == 1'b1, "R7 resume tracking", int'(sample_on), 1);
        step(); step();
    endtask

    initial begin
        int seen;
        step(); step();
        check(sample_on == 0 && conv_start == 0 && conv_done == 0 && ref_pwr_req == 0,
              "R1 reset state", int'({sample_on, conv_start, conv_done, ref_pwr_req}), 0);
        rst_n = 1'b1;
        step();
        // R1: trigger while disabled
        trig_in = 1'b1;
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (sample_on || conv_start || ref_pwr_req) seen++;
        end
        trig_in = 1'b0;
        check(seen == 0, "R1 disabled ignores trigger", seen, 0);
        step();
        enable = 1'b1;
        soft_rst_n = 1'b1;
        step();
        check(ref_pwr_req == 1'b0, "R9 sync idle no keep", int'(ref_pwr_req), 0);
        ref_keep = 1'b1;
        #1;
        check(ref_pwr_req == 1'b1, "R9 sync idle keep", int'(ref_pwr_req), 1);
        ref_keep = 1'b0;
        step();
        // R3 sweep of exponent codes
        for (int e = 0; e <= 12; e++) sync_run(e, 1'b0);
        sync_run(15, 1'b0);
        // R8 retrigger during window and conversion
        sync_run(4, 1'b1);
        // R10 soft reset mid-window
        smpl_exp = 4'd5;
        trig_in = 1'b1;
        step(); step(); step();
        trig_in = 1'b0;
        for (int i = 0; i < 10; i++) step();
        soft_rst_n = 1'b0;
        step();
        check(sample_on == 1'b0 && conv_start == 1'b0, "R10 soft reset idles",
              int'(sample_on), 0);
        soft_rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 80; i++) begin
            step();
            if (sample_on || conv_start) seen++;
        end
        check(seen == 0, "R10 no resume", seen, 0);
        // Asynchronous mode: configure under soft reset
        soft_rst_n = 1'b0;
        async_mode = 1'b1;
        step();
        soft_rst_n = 1'b1;
        step();
        async_run(0);
        async_run(15);
        enable = 1'b0;
        step();
        check(sample_on == 0 && ref_pwr_req == 0, "R1 disable idles",
              int'({sample_on, ref_pwr_req}), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", c_dummy(), 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic int c_dummy();
        return WATCHDOG;
    endfunction

endmodule